// File: doc/BRIEF.md
# Three-Wire Synthesiser Control Word Receiver

This block receives the serial programming word of a PLL frequency synthesiser over three lines: serial data, serial clock and a framing enable. Bits are captured MSB first on rising serial-clock edges, and only while the enable is high. When the enable falls, a word of the correct length is parked in a pending buffer. The word is applied to the active control registers only when the programmable divider signals the end of a division cycle. The divider ratio therefore never changes in the middle of a count, and fine-tuning steps apply cleanly.

The three serial lines are asynchronous to the system clock. Each passes through a parameterised synchroniser before edge detection. The divider sync pulse is a one-cycle strobe in the system clock domain. An elaboration parameter selects one of two word formats. The long format is 28 bits and carries four port-select bits. The short format is 26 bits and carries two. The decoded fields drive the divider, the prescaler, the reference divider, the charge pump, the test mux, the varactor drive and the port outputs.

Top module: `tw_synth_prog`

## Requirements
- R1: After reset, every decoded output is 0. The pending flag and the length-error flag are also 0, so the ports are off, the drive is enabled and test mode is off.
- R2: Rising edges of the serial clock while the enable is low change nothing. A word framed after such edges decodes exactly as if they had not occurred.
- R3: Long format (LONG_FMT=1, 28 bits, MSB first): the first 17 bits are ratio_o (MSB first), then presc_en_o, cp_hi_o, test_o, drv_off_o, 3 bits of ref_sel_o (MSB first), then 4 bits of port_o (bit 3 first).
- R4: Short format (LONG_FMT=0, 26 bits): the layout is the same as the long format, but only port_o[1:0] is carried, and port_o[3:2] stay 0.
- R5: An enable fall after exactly the format's bit count sets pending_o. The active outputs do not change until a divider sync arrives.
- R6: A div_sync pulse while a word is pending updates every decoded output on the next clock and clears pending_o.
- R7: A div_sync pulse with nothing pending leaves every output unchanged.
- R8: A second valid word received before the sync replaces the pending word, and only the second word is applied.
- R9: An enable fall after any other bit count discards the word. The active outputs and the pending state stay unchanged, and len_err_o is set.
- R10: len_err_o stays set until reset, whatever later words arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Frame enable, asynchronous; a fall ends a word |
| div_sync | input | 1 | One-cycle strobe at the end of a divider cycle |
| ratio_o | output | RATIO_W | Programmable divider ratio |
| presc_en_o | output | 1 | Prescaler enable |
| cp_hi_o | output | 1 | Charge-pump high-current select |
| test_o | output | 1 | Test mode select |
| drv_off_o | output | 1 | Varactor drive disable |
| ref_sel_o | output | REF_W | Reference division ratio select |
| port_o | output | 4 | Port outputs (upper two are 0 in the short format) |
| pending_o | output | 1 | A received word waits for div_sync |
| len_err_o | output | 1 | Sticky: a word of the wrong length was seen |

## Verification
The bench drives one set of serial lines into a long-format instance and a short-format instance together, so every frame is a good word for at most one of them and a length error for the other. It sends serial clocks while the enable is low, and a design that shifted on those would misplace every field. It sends two words before a single sync, and a design that kept the first would show stale fields. It sends syncs with nothing pending, and a design that reloaded from a stale buffer would change its outputs. Random words with a fixed seed catch any swapped or shifted field boundary, and 27-bit frames check that a short word is neither applied nor allowed to clear the sticky error.

// File: rtl/tw_pkg.sv
package tw_pkg;
   parameter int TW_PORT_LONG  = 4;
   parameter int TW_PORT_SHORT = 2;
   parameter int TW_PORT_OUT   = 4;
   // fixed per-word control bits: prescaler, charge pump, test, drive off
   parameter int TW_FLAG_BITS  = 4;

   typedef enum logic [1:0] {
      LD_NONE = 2'd0,
      LD_GOOD = 2'd1,
      LD_BAD  = 2'd2
   } load_e;
endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl  = chain_q[STAGES-1];
   assign rise = chain_q[STAGES-1] & ~prev_q;
   assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tw_shift_rx.sv
module tw_shift_rx
   import tw_pkg::*;
#(
   parameter int WORD_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_lvl,
   input  logic              en_rise,
   input  logic              en_fall,
   input  logic              sck_rise,
   input  logic              sdi_lvl,
   output logic [WORD_W-1:0] word_o,
   output load_e             ld_o
);
   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

   logic [WORD_W-1:0] shreg_q;
   logic [CNT_W-1:0]  cnt_q;
   load_e             ld_q;
   logic              take_bit;

   assign take_bit = sck_rise & en_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q <= '0;
      end else if (take_bit) begin
         shreg_q <= {shreg_q[WORD_W-2:0], sdi_lvl};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (en_rise) begin
         cnt_q <= take_bit ? CNT_W'(1) : '0;
      end else if (take_bit && cnt_q != CNT_SAT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_q <= LD_NONE;
      end else if (en_fall) begin
         ld_q <= (cnt_q == CNT_FULL) ? LD_GOOD : LD_BAD;
      end else begin
         ld_q <= LD_NONE;
      end
   end

   assign word_o = shreg_q;
   assign ld_o   = ld_q;

   // R2
   shift_only_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(shreg_q) |-> $past(en_lvl));

   // R5
   load_only_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_q != LD_NONE) |-> $past(en_fall));
endmodule

// File: rtl/tw_ctrl_regs.sv
module tw_ctrl_regs
   import tw_pkg::*;
#(
   parameter int WORD_W   = 28,
   parameter int RATIO_W  = 17,
   parameter int REF_W    = 3,
   parameter int PORT_W   = 4,
   parameter int PORT_OUT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  load_e              ld_i,
   input  logic [WORD_W-1:0]  word_i,
   input  logic               div_sync,
   output logic [RATIO_W-1:0] ratio_o,
   output logic               presc_en_o,
   output logic               cp_hi_o,
   output logic               test_o,
   output logic               drv_off_o,
   output logic [REF_W-1:0]   ref_sel_o,
   output logic [PORT_OUT-1:0] port_o,
   output logic               pending_o,
   output logic               len_err_o
);
   localparam int REF_LSB   = PORT_W;
   localparam int DRV_BIT   = REF_LSB + REF_W;
   localparam int TEST_BIT  = DRV_BIT + 1;
   localparam int CP_BIT    = TEST_BIT + 1;
   localparam int PRE_BIT   = CP_BIT + 1;
   localparam int RATIO_LSB = PRE_BIT + 1;

   logic [WORD_W-1:0] pend_q;
   logic [WORD_W-1:0] act_q;
   logic              pending_q;
   logic              err_q;
   logic              commit;

   assign commit = div_sync & pending_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= '0;
         pending_q <= 1'b0;
      end else if (ld_i == LD_GOOD) begin
         pend_q    <= word_i;
         pending_q <= 1'b1;
      end else if (commit) begin
         pending_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (commit) begin
         act_q <= pend_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (ld_i == LD_BAD) begin
         err_q <= 1'b1;
      end
   end

   assign ratio_o    = act_q[RATIO_LSB +: RATIO_W];
   assign presc_en_o = act_q[PRE_BIT];
   assign cp_hi_o    = act_q[CP_BIT];
   assign test_o     = act_q[TEST_BIT];
   assign drv_off_o  = act_q[DRV_BIT];
   assign ref_sel_o  = act_q[REF_LSB +: REF_W];
   assign pending_o  = pending_q;
   assign len_err_o  = err_q;

   generate
      if (PORT_OUT > PORT_W) begin : g_port_pad
         assign port_o = {{(PORT_OUT-PORT_W){1'b0}}, act_q[PORT_W-1:0]};
      end else begin : g_port_full
         assign port_o = act_q[PORT_OUT-1:0];
      end
   endgenerate

   // R5
   good_load_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_i == LD_GOOD) |=> pending_q);

   // R6
   commit_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_sync && pending_q && ld_i != LD_GOOD) |=> !pending_q);

   // R7
   active_moves_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_q) |-> $past(div_sync && pending_q));

   // R9
   bad_load_sets_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_i == LD_BAD && !div_sync) |=> (err_q && $stable(pending_q) && $stable(pend_q)));

   // R10
   error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/tw_synth_prog.sv
module tw_synth_prog
   import tw_pkg::*;
#(
   parameter int LONG_FMT    = 1,
   parameter int RATIO_W     = 17,
   parameter int REF_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_data,
   input  logic               ser_en,
   input  logic               div_sync,
   output logic [RATIO_W-1:0] ratio_o,
   output logic               presc_en_o,
   output logic               cp_hi_o,
   output logic               test_o,
   output logic               drv_off_o,
   output logic [REF_W-1:0]   ref_sel_o,
   output logic [3:0]         port_o,
   output logic               pending_o,
   output logic               len_err_o
);
   localparam int PORT_W = (LONG_FMT != 0) ? TW_PORT_LONG : TW_PORT_SHORT;
   localparam int WORD_W = RATIO_W + TW_FLAG_BITS + REF_W + PORT_W;
   localparam int N_LINES = 3;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tw_synth_prog: SYNC_STAGES must be at least 2");
      end
      if (RATIO_W < 2 || RATIO_W > 24) begin : g_bad_ratio
         $error("tw_synth_prog: RATIO_W out of range 2..24");
      end
      if (REF_W < 1 || REF_W > 8) begin : g_bad_ref
         $error("tw_synth_prog: REF_W out of range 1..8");
      end
   endgenerate

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] lvl_s, rise_s, fall_s;

   // line 0: enable, line 1: serial clock, line 2: serial data
   assign raw_lines = {ser_data, ser_clk, ser_en};

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         tw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_lines[i]),
            .lvl  (lvl_s[i]),
            .rise (rise_s[i]),
            .fall (fall_s[i])
         );
      end
   endgenerate

   logic [WORD_W-1:0] rx_word;
   load_e             rx_ld;

   tw_shift_rx #(.WORD_W(WORD_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_lvl  (lvl_s[0]),
      .en_rise (rise_s[0]),
      .en_fall (fall_s[0]),
      .sck_rise(rise_s[1]),
      .sdi_lvl (lvl_s[2]),
      .word_o  (rx_word),
      .ld_o    (rx_ld)
   );

   tw_ctrl_regs #(
      .WORD_W  (WORD_W),
      .RATIO_W (RATIO_W),
      .REF_W   (REF_W),
      .PORT_W  (PORT_W),
      .PORT_OUT(TW_PORT_OUT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_i      (rx_ld),
      .word_i    (rx_word),
      .div_sync  (div_sync),
      .ratio_o   (ratio_o),
      .presc_en_o(presc_en_o),
      .cp_hi_o   (cp_hi_o),
      .test_o    (test_o),
      .drv_off_o (drv_off_o),
      .ref_sel_o (ref_sel_o),
      .port_o    (port_o),
      .pending_o (pending_o),
      .len_err_o (len_err_o)
   );

   // R4
   short_port_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (LONG_FMT == 0) |-> (port_o[3:2] == 2'b00));
endmodule

// File: tb/sim_tw_synth_prog.sv
`timescale 1ns/1ps
module sim_tw_synth_prog;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0, div_sync = 1'b0;

   always #5 clk = ~clk;

   logic [16:0] l_ratio, s_ratio;
   logic        l_pre, l_cp, l_test, l_drv, s_pre, s_cp, s_test, s_drv;
   logic [2:0]  l_ref, s_ref;
   logic [3:0]  l_port, s_port;
   logic        l_pend, l_err, s_pend, s_err;

   tw_synth_prog #(.LONG_FMT(1)) u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_en(ser_en), .div_sync(div_sync), .ratio_o(l_ratio),
      .presc_en_o(l_pre), .cp_hi_o(l_cp), .test_o(l_test), .drv_off_o(l_drv),
      .ref_sel_o(l_ref), .port_o(l_port), .pending_o(l_pend), .len_err_o(l_err));

   tw_synth_prog #(.LONG_FMT(0)) u1 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_en(ser_en), .div_sync(div_sync), .ratio_o(s_ratio),
      .presc_en_o(s_pre), .cp_hi_o(s_cp), .test_o(s_test), .drv_off_o(s_drv),
      .ref_sel_o(s_ref), .port_o(s_port), .pending_o(s_pend), .len_err_o(s_err));

   int n_run = 0, n_fail = 0;

   // reference state for each format
   logic [27:0] la_act = '0, la_pend = '0;
   logic        la_pf = 1'b0, la_err = 1'b0;
   logic [25:0] sa_act = '0, sa_pend = '0;
   logic        sa_pf = 1'b0, sa_err = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wcyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check_all(input string req);
      logic [31:0] lgot, sgot;
      lgot = {4'h0, l_ratio, l_pre, l_cp, l_test, l_drv, l_ref, l_port};
      sgot = {6'h0, s_ratio, s_pre, s_cp, s_test, s_drv, s_ref, s_port[1:0]};
      chk(lgot == {4'h0, la_act}, req, "long fields R3", lgot, {4'h0, la_act});
      chk(l_pend == la_pf, req, "long pending", 32'(l_pend), 32'(la_pf));
      chk(l_err == la_err, req, "long len_err", 32'(l_err), 32'(la_err));
      chk(sgot == {6'h0, sa_act}, req, "short fields R4", sgot, {6'h0, sa_act});
      chk(s_port[3:2] == 2'b00, req, "short upper ports R4", 32'(s_port[3:2]), 32'h0);
      chk(s_pend == sa_pf, req, "short pending", 32'(s_pend), 32'(sa_pf));
      chk(s_err == sa_err, req, "short len_err", 32'(s_err), 32'(sa_err));
   endtask

   // frame of n bits, MSB first; junk serial clocks with enable low before it
   task automatic send_frame(input logic [31:0] w, input int n, input int junk);
      for (int j = 0; j < junk; j++) begin
         ser_data = $urandom_range(0, 1);
         wcyc(3); ser_clk = 1'b1; wcyc(3); ser_clk = 1'b0;
      end
      wcyc(3);
      ser_en = 1'b1;
      wcyc(3);
      for (int i = n - 1; i >= 0; i--) begin
         ser_data = w[i];
         wcyc(3); ser_clk = 1'b1; wcyc(3); ser_clk = 1'b0;
      end
      wcyc(3);
      ser_en = 1'b0;
      wcyc(8);
      if (n == 28) begin la_pend = w[27:0]; la_pf = 1'b1; end else la_err = 1'b1;
      if (n == 26) begin sa_pend = w[25:0]; sa_pf = 1'b1; end else sa_err = 1'b1;
   endtask

   task automatic pulse_sync();
      div_sync = 1'b1;
      wcyc(1);
      div_sync = 1'b0;
      wcyc(2);
      if (la_pf) begin la_act = la_pend; la_pf = 1'b0; end
      if (sa_pf) begin sa_act = sa_pend; sa_pf = 1'b0; end
   endtask

   initial begin
      logic [31:0] w;
      int n;
      void'($urandom(32'h5EED_0042));
      wcyc(4);
      rst_n = 1'b1;
      wcyc(2);
      check_all("R1");

      // R2: junk clocks with enable low, then a long frame; R5: pending, outputs held
      send_frame(32'h0A5C_3E96, 28, 5);
      check_all("R5");
      pulse_sync();
      check_all("R6");
      pulse_sync();
      check_all("R7");

      // R8: two frames before one sync
      send_frame(32'h0123_4567, 28, 0);
      send_frame(32'h0FED_CBA9, 28, 2);
      check_all("R8");
      pulse_sync();
      check_all("R8");

      // R4: short frame, all-ones boundary, with junk clocks
      send_frame(32'h03FF_FFFF, 26, 3);
      check_all("R9");
      pulse_sync();
      check_all("R4");

      // R9: one bit short for long format, one over for short
      send_frame(32'h07FF_FFFF, 27, 0);
      check_all("R9");
      pulse_sync();
      check_all("R10");

      // random mix
      for (int k = 0; k < 30; k++) begin
         w = $urandom;
         case ($urandom_range(0, 4))
            0, 1: n = 28;
            2, 3: n = 26;
            default: n = 27;
         endcase
         send_frame(w, n, $urandom_range(0, 2));
         check_all("R3");
         if ($urandom_range(0, 3) != 0) begin
            pulse_sync();
            check_all("R6");
         end
      end
      pulse_sync();
      check_all("R10");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule